// File: doc/BRIEF.md
# Half-Rate Rotational Fine Frequency Detector

This block is the digital back end of a fine frequency detector for a clock and data recovery loop. It runs on a half-rate reference clock. In each period it receives the data samples taken on the rising edges of the equally spaced phases of that clock. The sampling flip-flops belong to the bang-bang phase detector and are not rebuilt here. With four phases the samples are 0.5 UI apart and are called intervals A, B, C and D.

When the input carries an alternating 0101 data stream at close to the clock rate, each period shows exactly one rising transition. The block finds the interval that holds that transition. It then follows how this position rotates from one reference edge to the next. A wrap from the first interval to the last means the data runs faster than the clock, and the block fires a one-cycle up pulse. A wrap from the last interval to the first means the data runs slower, and the block fires a one-cycle down pulse. All other sample patterns are ignored. A counter raises a fine-lock flag once both pulses have stayed quiet for a set number of unit intervals.

Top module: `halfrate_fine_fd`

## Requirements
- R1: While `rst_n` is low, `up_o`, `dn_o` and `locked_o` are 0 and no previous transition position is held.
- R2: `samp_i[0]` is interval A, `samp_i[1]` is B, `samp_i[2]` is C and `samp_i[3]` is D. A period is valid only when it holds two cyclically adjacent ones and two zeros. The transition position is the interval of the first 1, so that (A,B,C,D) = 1100 gives A, 0110 gives B, 0011 gives C and 1001 gives D.
- R3: An invalid period (for example 0000, 1111 or 1010 in A..D order) produces no pulse and leaves the stored position unchanged.
- R4: A valid period at position D whose stored position is A makes `up_o` high for the one cycle after that clock edge.
- R5: A valid period at position A whose stored position is D makes `dn_o` high for the one cycle after that clock edge.
- R6: An unchanged position, a move to a non-wrapping neighbour, or a two-interval jump produces no pulse. The new position is still stored.
- R7: The first valid period after reset only stores its position and produces no pulse.
- R8: `up_o` and `dn_o` are never high together, and neither is high for two cycles in a row.
- R9: `locked_o` rises after 1024 UI without a pulse. This is 512 consecutive reference edges at 2 UI per period, counted from reset or from the edge that clears the counter.
- R10: An up or down pulse clears the lock counter at the next edge, so `locked_o` is low in the cycle after the pulse. Lock returns only after a further 512 quiet edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | 4 | Data samples of one period, bit 0 = interval A |
| up_o | output | 1 | One-cycle pulse: raise the oscillator frequency |
| dn_o | output | 1 | One-cycle pulse: lower the oscillator frequency |
| locked_o | output | 1 | Fine frequency lock flag |

## Verification
The checker watches every cycle for the following:
- the two pulses never overlap and never last more than one cycle;
- a period whose ones count is wrong is never followed by a pulse;
- a pulse always drops the lock flag in the next cycle;
- the lock flag never rises right after a pulse.

Other behaviour depends on history and only the bench scenarios can show it. These are the rotation direction, keeping the stored position across invalid periods, ignoring jumps, the silent first period after reset, and the exact 512-edge lock boundary, both from reset and after a clear.

// File: rtl/hrfd_pkg.sv
package hrfd_pkg;
   localparam int HRFD_MAX_PHASES = 16;

   typedef struct packed {
      logic up;
      logic dn;
   } hrfd_dir_t;
endpackage

// File: rtl/hrfd_pos_decode.sv
module hrfd_pos_decode #(
   parameter int NPH = 4,
   localparam int PW = $clog2(NPH)
) (
   input  logic [NPH-1:0] samp,
   output logic           valid,
   output logic [PW-1:0]  pos
);
   // pattern with the rising transition in interval k
   function automatic logic [NPH-1:0] rot_pat(input int k);
      logic [NPH-1:0] p;
      for (int i = 0; i < NPH; i++) begin
         p[i] = (((i - k + NPH) % NPH) < (NPH / 2));
      end
      return p;
   endfunction

   logic [NPH-1:0] match;

   for (genvar k = 0; k < NPH; k++) begin : g_pat
      localparam logic [NPH-1:0] PAT = rot_pat(k);
      assign match[k] = (samp == PAT);
   end

   always_comb begin
      pos = '0;
      for (int k = 0; k < NPH; k++) begin
         if (match[k]) pos = pos | PW'(k);
      end
   end

   assign valid = |match;
endmodule

// File: rtl/hrfd_track.sv
module hrfd_track
   import hrfd_pkg::*;
#(
   parameter int NPH = 4,
   localparam int PW = $clog2(NPH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic [PW-1:0] pos,
   output hrfd_dir_t     dir
);
   localparam logic [PW-1:0] POS_FIRST = '0;
   localparam logic [PW-1:0] POS_LAST  = PW'(NPH - 1);

   logic          have_prev;
   logic [PW-1:0] prev_pos;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_pos  <= '0;
         dir       <= '0;
      end else if (valid) begin
         have_prev <= 1'b1;
         prev_pos  <= pos;
         dir.up    <= have_prev && (prev_pos == POS_FIRST) && (pos == POS_LAST);
         dir.dn    <= have_prev && (prev_pos == POS_LAST) && (pos == POS_FIRST);
      end else begin
         dir <= '0;
      end
   end
endmodule

// File: rtl/hrfd_lock_timer.sv
module hrfd_lock_timer #(
   parameter int LOCK_CYC = 512,
   localparam int CW = $clog2(LOCK_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   output logic locked
);
   localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || pulse) begin
         cnt <= '0;
      end else if (cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign locked = (cnt == LIMIT);
endmodule

// File: rtl/halfrate_fine_fd.sv
module halfrate_fine_fd
   import hrfd_pkg::*;
#(
   parameter int NPH     = 4,
   parameter int LOCK_UI = 1024,
   localparam int PW         = $clog2(NPH),
   localparam int UI_PER_CYC = NPH / 2,
   localparam int LOCK_CYC   = LOCK_UI / UI_PER_CYC
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] samp_i,
   output logic           up_o,
   output logic           dn_o,
   output logic           locked_o
);
   if (NPH < 4 || (NPH % 2) != 0 || NPH > HRFD_MAX_PHASES) begin : g_bad_nph
      $error("halfrate_fine_fd: NPH must be even and within 4..16");
   end
   if (LOCK_UI < UI_PER_CYC || (LOCK_UI % UI_PER_CYC) != 0) begin : g_bad_lock
      $error("halfrate_fine_fd: LOCK_UI must be a multiple of UI per cycle");
   end

   logic          pat_valid;
   logic [PW-1:0] pat_pos;
   hrfd_dir_t     dir;

   hrfd_pos_decode #(.NPH(NPH)) i_decode (
      .samp  (samp_i),
      .valid (pat_valid),
      .pos   (pat_pos)
   );

   hrfd_track #(.NPH(NPH)) i_track (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (pat_valid),
      .pos   (pat_pos),
      .dir   (dir)
   );

   hrfd_lock_timer #(.LOCK_CYC(LOCK_CYC)) i_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .pulse  (dir.up | dir.dn),
      .locked (locked_o)
   );

   assign up_o = dir.up;
   assign dn_o = dir.dn;
endmodule

// File: rtl/halfrate_fine_fd_chk.sv
module halfrate_fine_fd_chk #(
   parameter int NPH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NPH-1:0] samp_i,
   input logic           up_o,
   input logic           dn_o,
   input logic           locked_o
);
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_o && dn_o));

   a_r8_up_single: assert property (@(posedge clk) disable iff (!rst_n)
      up_o |=> !up_o);

   a_r8_dn_single: assert property (@(posedge clk) disable iff (!rst_n)
      dn_o |=> !dn_o);

   a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(samp_i) != NPH / 2) |=> (!up_o && !dn_o));

   a_r10_pulse_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (up_o || dn_o) |=> !locked_o);

   a_r9_lock_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(!up_o && !dn_o));
endmodule

bind halfrate_fine_fd halfrate_fine_fd_chk #(.NPH(NPH)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .samp_i   (samp_i),
   .up_o     (up_o),
   .dn_o     (dn_o),
   .locked_o (locked_o)
);

// File: tb/test_halfrate_fine_fd.sv
`timescale 1ns/1ps
module test_halfrate_fine_fd;
   // samp encoding {D,C,B,A}
   localparam logic [3:0] P_A = 4'b0011;
   localparam logic [3:0] P_B = 4'b0110;
   localparam logic [3:0] P_C = 4'b1100;
   localparam logic [3:0] P_D = 4'b1001;
   localparam int NV = 15;
   // {samp, up, dn}
   localparam logic [5:0] VEC [NV] = '{
      {P_A,     2'b00},  // R7 first valid
      {P_D,     2'b10},  // R4 A->D
      {P_D,     2'b00},  // R6 same
      {P_A,     2'b01},  // R5 D->A
      {P_B,     2'b00},  // R6 adjacent
      {P_D,     2'b00},  // R6 jump
      {4'b0000, 2'b00},  // R3 invalid
      {4'b1111, 2'b00},  // R3 invalid
      {4'b0101, 2'b00},  // R3 invalid
      {P_A,     2'b01},  // R3 stored D kept, R5
      {P_C,     2'b00},  // R6 jump
      {P_D,     2'b00},  // R6 adjacent
      {P_A,     2'b01},  // R5
      {P_D,     2'b10},  // R4
      {P_C,     2'b00}   // R2 R6
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] samp;
   logic       up, dn, locked;
   int         total = 0;
   int         bad = 0;

   always #2 clk = ~clk;

   halfrate_fine_fd i_halfrate_fine_fd (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_i   (samp),
      .up_o     (up),
      .dn_o     (dn),
      .locked_o (locked)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      samp  = 4'b0000;
      repeat (3) @(negedge clk);
      check("R1 up reset", up, 1'b0);
      check("R1 dn reset", dn, 1'b0);
      check("R1 locked reset", locked, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         samp = VEC[i][5:2];
         @(negedge clk);
         check($sformatf("R2 R4 vec%0d up", i), up, VEC[i][1]);
         check($sformatf("R2 R5 vec%0d dn", i), dn, VEC[i][0]);
         check($sformatf("R8 vec%0d exclusive", i), up & dn, 1'b0);
      end
      check("R10 no lock after pulses", locked, 1'b0);

      // R7: stored A dropped by reset, so A->D after reset stays silent
      samp = P_A;
      @(negedge clk);
      rst_n = 1'b0;
      samp  = 4'b0000;
      @(negedge clk);
      check("R1 up mid reset", up, 1'b0);
      check("R1 locked mid reset", locked, 1'b0);
      rst_n = 1'b1;
      samp  = P_D;
      @(negedge clk);
      check("R7 no up after reset", up, 1'b0);
      samp = 4'b0000;
      for (int n = 2; n <= 512; n++) begin
         @(negedge clk);
         if (n == 511) check("R9 not locked at 511", locked, 1'b0);
         if (n == 512) check("R9 locked at 512", locked, 1'b1);
      end

      // stored D, now A gives a down pulse
      samp = P_A;
      @(negedge clk);
      check("R5 dn while locked", dn, 1'b1);
      check("R10 lock held in pulse cycle", locked, 1'b1);
      samp = 4'b0000;
      @(negedge clk);
      check("R8 dn single cycle", dn, 1'b0);
      check("R10 lock dropped", locked, 1'b0);
      for (int n = 1; n <= 512; n++) begin
         @(negedge clk);
         if (n == 511) check("R10 not relocked at 511", locked, 1'b0);
         if (n == 512) check("R10 relocked at 512", locked, 1'b1);
      end
      check("R3 quiet on invalid", up | dn, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule